// File: doc/BRIEF.md
# Packet Step-Back Retraction Coordinator

This block handles a packet whose head flit cannot move forward. Instead of stalling the path or dropping the packet, it tells a fixed number of upstream hops to step back. The hops closest to the blockage throw away everything they hold for the packet. The hop farthest back rebuilds the packet from the copies it kept, in order. It then asks for a free output port other than the one that blocked. The chain of hops along the path is modelled inside the block as a parameterised array of copy stores, one per hop, with `DEPTH` slots each. Slot 0 holds the head flit and slots 1 to `DEPTH-1` hold the body flits that follow it. Route computation and the crossbar are outside this block.

A controller with six states drives the sequence:

- IDLE goes to WAIT_GRANT when an allocation attempt starts.
- WAIT_GRANT can exit in three ways:
  - It returns to IDLE on a grant.
  - It goes to NOTIFY on a refusal.
  - It goes to NOTIFY when the wait timer reaches its programmed limit.
- A new attempt during WAIT_GRANT restarts the wait in place.
- NOTIFY pulses the reverse notification for one cycle and then goes to PURGE.
- PURGE clears the near hops for one cycle and then goes to RESTORE.
- RESTORE replays the `DEPTH` copy slots of the restoring hop, one per cycle, and then goes to REROUTE.
- REROUTE stays until an eligible port is free. It then issues the reroute request together with the credit release and returns to IDLE.

Only one retraction is handled at a time.

Top module: `sbk_retract_top`

## Requirements
- R1: After reset, every output is zero.
- R2: With no grant, refusal or new attempt, NOTIFY starts `tmo_limit+1` cycles after the cycle in which the attempt was accepted. It is not entered earlier.
- R3: A refusal during WAIT_GRANT enters NOTIFY on the next clock.
- R4: A grant during WAIT_GRANT returns to IDLE, and neither a notification nor a purge follows.
- R5: The restoring hop is r = h-(DEPTH-1), or hop 0 when h < DEPTH-1, where h is the hop holding the blocked head. In NOTIFY, `notify_vec` has bits r..h-1 set. On the following cycle, `purge_vec` has bits r+1..h set, so min(h, DEPTH-1) hops are purged. Bit i of these vectors stands for hop i.
- R6: RESTORE lasts `DEPTH` cycles. In cycle k, `rst_valid` shows whether hop r holds slot k, `rst_data` carries that slot, and `rst_hop` equals r.
- R7: After a purge, the purged hops hold no copies. A later restore from such a hop outputs no valid flit.
- R8: The reroute port is the lowest-numbered port whose bit in `free_ports` is 1 and which differs from the blocked port. While no such port exists, REROUTE waits and `reroute_req` stays low.
- R9: `credit_ret` equals the purge mask, and only in the cycle where `reroute_req` is high. It is zero throughout NOTIFY, PURGE and RESTORE.
- R10: Attempt, grant and refusal inputs have no effect from NOTIFY through REROUTE. No new wait is latched by them.
- R11: A new attempt during WAIT_GRANT restarts the wait timer and replaces the head hop and blocked port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmo_limit | input | TW | Allocation wait limit in cycles |
| alloc_start | input | 1 | A head-flit allocation attempt begins |
| alloc_hop | input | HW | Hop holding the head flit |
| alloc_port | input | PW | Output port being requested |
| alloc_grant | input | 1 | Allocation granted |
| alloc_refuse | input | 1 | Allocation refused |
| free_ports | input | NPORT | Free output ports at the restoring hop |
| cp_we | input | 1 | Write a copy slot |
| cp_hop | input | HW | Hop of the copy write |
| cp_slot | input | SW | Slot of the copy write (0 = head) |
| cp_data | input | FW | Flit written |
| notify_vec | output | NHOPS | Reverse retraction notification per hop |
| purge_vec | output | NHOPS | Per-hop purge strobe |
| rst_valid | output | 1 | Restored flit valid |
| rst_data | output | FW | Restored flit |
| rst_hop | output | HW | Hop doing the restore |
| reroute_req | output | 1 | Forward the restored packet |
| reroute_port | output | PW | Port chosen for the restored packet |
| credit_ret | output | NHOPS | Credit release for purged hops |

## Verification
The bench builds the block with seven hops, depth 4 and four ports. Blocking at hops 0 to 2 therefore exercises the clamp to the injection hop, and hops 3 to 6 exercise the full step back of three purged hops. Timer limits 0 to 5 cover the immediate timeout and a restart in mid-wait. Running copies are left unrefreshed between some retractions, so restores from earlier-purged or partly filled hops show up as missing flits. Free-port masks that leave only the blocked port open hold the controller in REROUTE.

// File: rtl/sbk_pkg.sv
package sbk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_NOTIFY,
        ST_PURGE,
        ST_RESTORE,
        ST_REROUTE
    } rc_state_e;
endpackage

// File: rtl/sbk_hop_store.sv
module sbk_hop_store #(
    parameter int DEPTH = 4,
    parameter int FW    = 16,
    parameter int SW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_slot,
    input  logic [FW-1:0] wr_data,
    input  logic          purge,
    input  logic [SW-1:0] rd_slot,
    output logic          rd_valid,
    output logic [FW-1:0] rd_data
);
    logic [DEPTH-1:0] held_q;
    logic [FW-1:0]    data_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= '0;
        else if (purge)
            held_q <= '0;
        else if (wr_en)
            held_q[wr_slot] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en && !purge)
            data_q[wr_slot] <= wr_data;
    end

    assign rd_valid = held_q[rd_slot];
    assign rd_data  = data_q[rd_slot];

    // R7
    purge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        purge |=> (held_q == '0));
endmodule

// File: rtl/sbk_port_pick.sv
module sbk_port_pick #(
    parameter int NPORT = 4,
    parameter int PW    = 2
) (
    input  logic [NPORT-1:0] free_ports,
    input  logic [PW-1:0]    blk_port,
    output logic             ok,
    output logic [PW-1:0]    port
);
    always_comb begin
        ok   = 1'b0;
        port = '0;
        for (int i = NPORT - 1; i >= 0; i--) begin
            if (free_ports[i] && (PW'(i) != blk_port)) begin
                ok   = 1'b1;
                port = PW'(i);
            end
        end
    end
endmodule

// File: rtl/sbk_ctrl.sv
module sbk_ctrl
    import sbk_pkg::*;
#(
    parameter int NHOPS = 8,
    parameter int DEPTH = 4,
    parameter int TW    = 8,
    parameter int HW    = 3,
    parameter int PW    = 2,
    parameter int SW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TW-1:0]    tmo_limit,
    input  logic             alloc_start,
    input  logic [HW-1:0]    alloc_hop,
    input  logic [PW-1:0]    alloc_port,
    input  logic             alloc_grant,
    input  logic             alloc_refuse,
    input  logic             pick_ok,
    output rc_state_e        st,
    output logic [HW-1:0]    rhop_q,
    output logic [PW-1:0]    blk_q,
    output logic [SW-1:0]    rd_idx,
    output logic [NHOPS-1:0] span_vec,
    output logic [NHOPS-1:0] notify_vec,
    output logic [NHOPS-1:0] purge_vec
);
    localparam logic [HW-1:0] BACK = HW'(DEPTH - 1);
    localparam logic [SW-1:0] LAST = SW'(DEPTH - 1);

    rc_state_e     st_d;
    logic [HW-1:0] head_q;
    logic [TW-1:0] timer_q;
    logic          capture;

    assign capture = alloc_start &&
                     ((st == ST_IDLE) ||
                      ((st == ST_WAIT) && !alloc_grant && !alloc_refuse));

    always_comb begin
        st_d = st;
        unique case (st)
            ST_IDLE:    if (alloc_start) st_d = ST_WAIT;
            ST_WAIT: begin
                if (alloc_grant)               st_d = ST_IDLE;
                else if (alloc_refuse)         st_d = ST_NOTIFY;
                else if (alloc_start)          st_d = ST_WAIT;
                else if (timer_q == tmo_limit) st_d = ST_NOTIFY;
            end
            ST_NOTIFY:  st_d = ST_PURGE;
            ST_PURGE:   st_d = ST_RESTORE;
            ST_RESTORE: if (rd_idx == LAST) st_d = ST_REROUTE;
            ST_REROUTE: if (pick_ok) st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            head_q  <= '0;
            rhop_q  <= '0;
            blk_q   <= '0;
            timer_q <= '0;
            rd_idx  <= '0;
        end else begin
            st <= st_d;
            if (capture) begin
                head_q  <= alloc_hop;
                blk_q   <= alloc_port;
                rhop_q  <= (alloc_hop >= BACK) ? (alloc_hop - BACK) : '0;
                timer_q <= '0;
            end else if (st == ST_WAIT) begin
                timer_q <= timer_q + 1'b1;
            end
            if (st == ST_PURGE)
                rd_idx <= '0;
            else if (st == ST_RESTORE)
                rd_idx <= rd_idx + 1'b1;
        end
    end

    always_comb begin
        for (int i = 0; i < NHOPS; i++) begin
            span_vec[i]   = (HW'(i) > rhop_q) && (HW'(i) <= head_q);
            notify_vec[i] = (st == ST_NOTIFY) &&
                            (HW'(i) >= rhop_q) && (HW'(i) < head_q);
        end
        purge_vec = (st == ST_PURGE) ? span_vec : '0;
    end

    // R5
    purge_after_notify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PURGE) |-> ($past(st) == ST_NOTIFY));
    // R5
    purge_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(purge_vec) <= DEPTH - 1);
    // R10
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RESTORE) |=> $stable(head_q) && $stable(blk_q));
    // R3
    refuse_notify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && alloc_refuse && !alloc_grant) |=> (st == ST_NOTIFY));
endmodule

// File: rtl/sbk_retract_top.sv
module sbk_retract_top
    import sbk_pkg::*;
#(
    parameter int NHOPS = 8,
    parameter int DEPTH = 4,
    parameter int NPORT = 4,
    parameter int FW    = 16,
    parameter int TW    = 8,
    localparam int HW   = (NHOPS > 1) ? $clog2(NHOPS) : 1,
    localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int SW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TW-1:0]    tmo_limit,
    input  logic             alloc_start,
    input  logic [HW-1:0]    alloc_hop,
    input  logic [PW-1:0]    alloc_port,
    input  logic             alloc_grant,
    input  logic             alloc_refuse,
    input  logic [NPORT-1:0] free_ports,
    input  logic             cp_we,
    input  logic [HW-1:0]    cp_hop,
    input  logic [SW-1:0]    cp_slot,
    input  logic [FW-1:0]    cp_data,
    output logic [NHOPS-1:0] notify_vec,
    output logic [NHOPS-1:0] purge_vec,
    output logic             rst_valid,
    output logic [FW-1:0]    rst_data,
    output logic [HW-1:0]    rst_hop,
    output logic             reroute_req,
    output logic [PW-1:0]    reroute_port,
    output logic [NHOPS-1:0] credit_ret
);
    rc_state_e        st;
    logic [HW-1:0]    rhop_q;
    logic [PW-1:0]    blk_q;
    logic [SW-1:0]    rd_idx;
    logic [NHOPS-1:0] span_vec;
    logic             pick_ok;
    logic [PW-1:0]    pick_port;
    logic [NHOPS-1:0] hop_v;
    logic [FW-1:0]    hop_d [NHOPS];

    sbk_ctrl #(
        .NHOPS(NHOPS), .DEPTH(DEPTH), .TW(TW), .HW(HW), .PW(PW), .SW(SW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tmo_limit(tmo_limit),
        .alloc_start(alloc_start), .alloc_hop(alloc_hop), .alloc_port(alloc_port),
        .alloc_grant(alloc_grant), .alloc_refuse(alloc_refuse), .pick_ok(pick_ok),
        .st(st), .rhop_q(rhop_q), .blk_q(blk_q), .rd_idx(rd_idx),
        .span_vec(span_vec), .notify_vec(notify_vec), .purge_vec(purge_vec)
    );

    sbk_port_pick #(.NPORT(NPORT), .PW(PW)) u_pick (
        .free_ports(free_ports), .blk_port(blk_q), .ok(pick_ok), .port(pick_port)
    );

    for (genvar g = 0; g < NHOPS; g++) begin : g_hop
        sbk_hop_store #(.DEPTH(DEPTH), .FW(FW), .SW(SW)) u_store (
            .clk(clk), .rst_n(rst_n),
            .wr_en(cp_we && (cp_hop == HW'(g))),
            .wr_slot(cp_slot), .wr_data(cp_data),
            .purge(purge_vec[g]),
            .rd_slot(rd_idx),
            .rd_valid(hop_v[g]), .rd_data(hop_d[g])
        );
    end

    always_comb begin
        rst_valid    = (st == ST_RESTORE) && hop_v[rhop_q];
        rst_data     = rst_valid ? hop_d[rhop_q] : '0;
        rst_hop      = (st == ST_RESTORE) ? rhop_q : '0;
        reroute_req  = (st == ST_REROUTE) && pick_ok;
        reroute_port = reroute_req ? pick_port : '0;
        credit_ret   = reroute_req ? span_vec : '0;
    end

    // R8
    reroute_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reroute_req |-> (reroute_port != blk_q) && free_ports[reroute_port]);
    // R9
    credit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (credit_ret != '0) |-> reroute_req);
    // R6
    restore_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_valid |-> ($past(st) == ST_PURGE) || ($past(st) == ST_RESTORE));
endmodule

// File: tb/sim_sbk_retract_top.sv
module sim_sbk_retract_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NH = 7;
    localparam int DP = 4;
    localparam int NP = 4;
    localparam int FW = 16;
    localparam int TW = 8;
    localparam int HW = 3;
    localparam int PW = 2;
    localparam int SW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [TW-1:0] tmo_limit = '0;
    logic alloc_start = 0, alloc_grant = 0, alloc_refuse = 0;
    logic [HW-1:0] alloc_hop = '0;
    logic [PW-1:0] alloc_port = '0;
    logic [NP-1:0] free_ports = '0;
    logic cp_we = 0;
    logic [HW-1:0] cp_hop = '0;
    logic [SW-1:0] cp_slot = '0;
    logic [FW-1:0] cp_data = '0;
    logic [NH-1:0] notify_vec, purge_vec, credit_ret;
    logic rst_valid, reroute_req;
    logic [FW-1:0] rst_data;
    logic [HW-1:0] rst_hop;
    logic [PW-1:0] reroute_port;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [FW-1:0] m_data [NH][DP];
    bit            m_ok   [NH][DP];

    always #2 clk = ~clk;

    sbk_retract_top #(.NHOPS(NH), .DEPTH(DP), .NPORT(NP), .FW(FW), .TW(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .tmo_limit(tmo_limit),
        .alloc_start(alloc_start), .alloc_hop(alloc_hop), .alloc_port(alloc_port),
        .alloc_grant(alloc_grant), .alloc_refuse(alloc_refuse), .free_ports(free_ports),
        .cp_we(cp_we), .cp_hop(cp_hop), .cp_slot(cp_slot), .cp_data(cp_data),
        .notify_vec(notify_vec), .purge_vec(purge_vec), .rst_valid(rst_valid),
        .rst_data(rst_data), .rst_hop(rst_hop), .reroute_req(reroute_req),
        .reroute_port(reroute_port), .credit_ret(credit_ret)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic int rhop(input int h);
        return (h >= DP - 1) ? h - (DP - 1) : 0;
    endfunction

    function automatic logic [NH-1:0] notify_mask(input int h);
        logic [NH-1:0] m = '0;
        for (int i = 0; i < NH; i++) if (i >= rhop(h) && i < h) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [NH-1:0] purge_mask(input int h);
        logic [NH-1:0] m = '0;
        for (int i = 0; i < NH; i++) if (i > rhop(h) && i <= h) m[i] = 1'b1;
        return m;
    endfunction

    function automatic int pick(input logic [NP-1:0] fr, input int b);
        for (int i = 0; i < NP; i++) if (fr[i] && i != b) return i;
        return -1;
    endfunction

    task automatic wr_copy(input int h, input int s, input logic [FW-1:0] d);
        cp_we = 1; cp_hop = HW'(h); cp_slot = SW'(s); cp_data = d;
        step();
        cp_we = 0;
        m_data[h][s] = d;
        m_ok[h][s] = 1;
    endtask

    task automatic fill(input bit sparse);
        for (int h = 0; h < NH; h++)
            for (int s = 0; s < DP; s++)
                if (!sparse || ($urandom % 4) != 0)
                    wr_copy(h, s, FW'($urandom));
    endtask

    // mode 0: refusal, 1: timeout. pre > 0: earlier attempt restarted after pre cycles (R11)
    task automatic run(input int h, input int b, input logic [NP-1:0] fr,
                       input int mode, input int lim, input int pre, input bit ign);
        int r = rhop(h);
        int p;
        tmo_limit = TW'(lim);
        free_ports = fr;
        if (pre > 0) begin
            alloc_start = 1; alloc_hop = HW'((h + 1) % NH); alloc_port = PW'(b);
            step();
            alloc_start = 0;
            for (int k = 1; k < pre; k++) begin
                chk("R11 no early notify", notify_vec, '0);
                step();
            end
        end
        alloc_start = 1; alloc_hop = HW'(h); alloc_port = PW'(b);
        step();
        alloc_start = 0;
        if (mode == 0) begin
            alloc_refuse = 1;
            step();
            alloc_refuse = 0;
        end else begin
            for (int k = 1; k <= lim + 1; k++) begin
                chk("R2 notify before limit", notify_vec, '0);
                step();
            end
        end
        chk(mode == 0 ? "R3 notify after refusal" : "R2 notify at timeout",
            notify_vec, notify_mask(h));
        chk("R5 notify span", notify_vec, notify_mask(h));
        step();
        chk("R5 purge span", purge_vec, purge_mask(h));
        chk("R9 no credit in purge", credit_ret, '0);
        for (int i = 0; i < NH; i++)
            if (purge_mask(h)[i]) for (int s = 0; s < DP; s++) m_ok[i][s] = 0;
        for (int s = 0; s < DP; s++) begin
            if (ign) begin
                alloc_start = 1; alloc_hop = HW'(NH - 1); alloc_grant = (s % 2) == 1;
                alloc_refuse = (s % 2) == 0;
            end
            step();
            chk("R6 restore valid", rst_valid, m_ok[r][s]);
            if (m_ok[r][s]) chk("R6 restore data", rst_data, m_data[r][s]);
            chk("R6 restore hop", rst_hop, r);
            chk("R9 no credit in restore", credit_ret, '0);
            chk("R7 no purge in restore", purge_vec, '0);
        end
        alloc_start = 0; alloc_grant = 0; alloc_refuse = 0;
        step();
        p = pick(fr, b);
        if (p < 0) begin
            for (int k = 0; k < 3; k++) begin
                chk("R8 wait for free port", reroute_req, 0);
                chk("R9 no credit while waiting", credit_ret, '0);
                step();
            end
            fr = fr | NP'(1 << ((b + 1) % NP));
            free_ports = fr;
            #0.1;
            p = pick(fr, b);
        end
        chk("R8 reroute issued", reroute_req, 1);
        chk("R8 reroute port", reroute_port, p);
        chk("R9 credit mask", credit_ret, purge_mask(h));
        step();
        chk("R1 idle after reroute", reroute_req, 0);
        if (ign) begin
            for (int k = 0; k < lim + 3; k++) begin
                chk("R10 nothing latched", notify_vec, '0);
                step();
            end
        end
    endtask

    initial begin
        #(4.0 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int h = 0; h < NH; h++) for (int s = 0; s < DP; s++) m_ok[h][s] = 0;
        repeat (3) step();
        chk("R1 reset notify", notify_vec, '0);
        chk("R1 reset reroute", reroute_req, 0);
        chk("R1 reset restore", rst_valid, 0);
        chk("R1 reset credit", credit_ret, '0);
        rst_n = 1;
        step();
        chk("R1 after reset purge", purge_vec, '0);
        fill(0);

        run(4, 1, 4'b0011, 0, 5, 0, 0);   // full step back, pick port 0
        run(5, 0, 4'b1111, 1, 3, 0, 0);   // restore from purged hop 2 (R7)
        run(1, 2, 4'b0100, 0, 5, 0, 0);   // clamp to injection, waits for port
        fill(0);
        run(0, 3, 4'b1000, 1, 0, 0, 0);   // head at injection, limit 0
        run(6, 2, 4'b0110, 1, 4, 3, 0);   // timer restart (R11)
        run(3, 1, 4'b1110, 0, 2, 0, 1);   // inputs ignored during retraction (R10)

        // R4 grant returns to idle
        tmo_limit = 3;
        alloc_start = 1; alloc_hop = 3; alloc_port = 0;
        step();
        alloc_start = 0; alloc_grant = 1;
        step();
        alloc_grant = 0;
        for (int k = 0; k < 8; k++) begin
            chk("R4 no notify after grant", notify_vec, '0);
            chk("R4 no purge after grant", purge_vec, '0);
            step();
        end

        for (int it = 0; it < 40; it++) begin
            if (($urandom % 3) == 0) fill(1);
            run($urandom % NH, $urandom % NP, NP'($urandom), $urandom % 2,
                $urandom % 6, 0, 0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule